// File: doc/BRIEF.md
# Low-Power Mode Wake Sequencer

This controller decides when a small processor core may execute instructions. Software asks it to park the core in Sleep or in one of two Idle flavours. The first flavour keeps the primary oscillator running. The second stops it. The controller then watches for a wake cause: an enabled interrupt flag or a watchdog time-out. It brings the core back through a fixed number of clock cycles:

- an oscillator start-up wait, only when the stopped primary clock is a crystal or PLL type that has to restart;
- a fixed settle interval, which always follows.

It also sequences the exit from reset. A crystal-type primary clock normally holds the core until the oscillator has counted out and reports ready. When two-speed start-up or the fail-safe monitor is enabled, the core instead starts at once on the internal oscillator and moves to the primary clock later. Two status bits say which source is driving execution. A one-cycle request tells the core whether to branch to the interrupt vector on resume.

Oscillator type codes on `osc_type`:

| Code | Type |
|------|------|
| 0 | low-power crystal |
| 1 | standard crystal |
| 2 | high-speed crystal |
| 3 | high-speed crystal with PLL |
| 4 | RC |
| 5 | external clock |
| 6 | internal oscillator |

Codes 0 to 3 are the crystal types.

Top module: `lp_wake_seq`

## Requirements
- R1: In Sleep or either Idle state, the block wakes exactly when some `irq_flag[i]` and `irq_en[i]` are both 1. A set flag whose enable is 0 leaves `cpu_run` at 0.
- R2: A one-cycle `wdt_tmo` pulse in Sleep or Idle wakes the core, and no vector branch is requested.
- R3: `vec_req` is a single-cycle pulse that coincides with the rise of `cpu_run`. It is 1 exactly when the wake was an interrupt wake and `gie` was 1 in the wake cycle.
- R4: When no oscillator wait is needed, `cpu_run` rises SETTLE_CYC+1 clock edges after the edge that registers the wake. This applies to a primary-keeping Idle with the primary clock up, and to non-crystal types.
- R5: For crystal types (codes 0 to 3) without fast start, a wake from Sleep or from the clock-stopping Idle takes OST_CYC+SETTLE_CYC+2 edges.
- R6: On reset exit with a crystal type and no fast start, `cpu_run` rises after OST_CYC+1 edges and waits for `pri_ready`. It rises one edge after `pri_ready` arrives once the count is done. Then `stat_pri`=1, `stat_int`=0 and `clk_int_sel`=0.
- R7: On reset exit with a non-crystal type, `cpu_run` rises on the first edge. Code 6 runs with `clk_int_sel`=1 and `stat_int`=1; other codes run with `stat_pri`=1.
- R8: With `two_speed_en` or `fail_safe_en` and a crystal type, `cpu_run` rises on the first edge after reset with `clk_int_sel`=1, `stat_int`=1 and `stat_pri`=0. `clk_int_sel` falls OST_CYC+1 edges after reset release.
- R9: `stat_pri` and `stat_int` are never 1 together.
- R10: Entering a low-power state before the primary clock is ready shuts the primary clock down. On a fast-start wake the core resumes on the internal clock, and `clk_int_sel` falls OST_CYC+2 edges after the wake edge.
- R11: In Run, `wdt_tmo` has no effect on `cpu_run`. `cpu_run` falls one edge after an entry request. `enter_sleep` wins over `enter_idle` when both are asserted.
- R12: While `rst` is 1, `cpu_run`, `vec_req`, `stat_pri`, `stat_int` and `clk_int_sel` are 0. The state register is one-hot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| irq_flag | input | N_IRQ | interrupt flags |
| irq_en | input | N_IRQ | per-source interrupt enables |
| gie | input | 1 | global interrupt enable |
| wdt_tmo | input | 1 | watchdog time-out pulse |
| enter_sleep | input | 1 | request to enter Sleep |
| enter_idle | input | 1 | request to enter Idle |
| idle_keep_pri | input | 1 | Idle flavour: 1 keeps the primary clock running |
| osc_type | input | 3 | primary oscillator type code |
| pri_ready | input | 1 | primary oscillator reports stable |
| two_speed_en | input | 1 | two-speed start-up enable |
| fail_safe_en | input | 1 | fail-safe clock monitor enable |
| cpu_run | output | 1 | core may execute |
| vec_req | output | 1 | branch to interrupt vector on resume |
| clk_int_sel | output | 1 | 1 selects the internal oscillator as core clock |
| stat_pri | output | 1 | primary clock is running execution |
| stat_int | output | 1 | internal clock is running execution |

## Verification
The bench builds the block with N_IRQ=3, SETTLE_CYC=5 and OST_CYC=20. The 3-bit flag and enable vectors allow all 64 flag/enable pairs to be swept through the clock-stopping Idle state. The short oscillator count keeps every crystal path within a few dozen cycles, so exact edge counts can be checked for each path:

- reset exit;
- start-up held back by a late `pri_ready`;
- fast start;
- both Idle flavours and Sleep.

Each count is compared with arithmetic on the two parameters.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  // one-hot state bit positions
  localparam int ST_RUN   = 0;
  localparam int ST_IPRI  = 1;
  localparam int ST_IOTH  = 2;
  localparam int ST_SLEEP = 3;
  localparam int ST_OSTW  = 4;
  localparam int ST_SETL  = 5;
  localparam int NSTATE   = 6;

  typedef logic [NSTATE-1:0] state_t;

  localparam logic [2:0] OSC_INTIO = 3'd6;

  // crystal and PLL types need a start-up count
  function automatic logic osc_is_xtal(input logic [2:0] t);
    return (t <= 3'd3);
  endfunction

  function automatic logic osc_is_int(input logic [2:0] t);
    return (t == OSC_INTIO);
  endfunction
endpackage

// File: rtl/lpw_wake_src.sv
module lpw_wake_src #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_tmo,
  output logic             irq_hit,
  output logic             wake
);
  logic [N_IRQ-1:0] armed;

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_src
      assign armed[g] = irq_flag[g] & irq_en[g];
    end
  endgenerate

  assign irq_hit = |armed;
  assign wake    = irq_hit | wdt_tmo;
endmodule

// File: rtl/lpw_ost_timer.sv
module lpw_ost_timer #(
  parameter int OST_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic start,
  input  logic pri_ready,
  output logic done
);
  localparam int CW = $clog2(OST_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(OST_CYC);

  logic          active;
  logic [CW-1:0] cnt;

  // out of reset the oscillator is assumed to be starting
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (kill) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = active & (cnt == LIMIT) & pri_ready;
endmodule

// File: rtl/lpw_settle_timer.sv
module lpw_settle_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= CW'(CYCLES - 1);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lp_wake_seq.sv
module lp_wake_seq
  import lpw_pkg::*;
#(
  parameter int N_IRQ      = 4,
  parameter int SETTLE_CYC = 8,
  parameter int OST_CYC    = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic             wdt_tmo,
  input  logic             enter_sleep,
  input  logic             enter_idle,
  input  logic             idle_keep_pri,
  input  logic [2:0]       osc_type,
  input  logic             pri_ready,
  input  logic             two_speed_en,
  input  logic             fail_safe_en,
  output logic             cpu_run,
  output logic             vec_req,
  output logic             clk_int_sel,
  output logic             stat_pri,
  output logic             stat_int
);
  state_t state_q, nxt;
  logic   irq_hit, wake;
  logic   pri_good, settle_zero;
  logic   ost_kill, ost_start, settle_load, wake_take;
  logic   waking_q, vec_pend_q;
  logic   xtal, intosc, fast, run_on_int, low_pwr;

  lpw_wake_src #(.N_IRQ(N_IRQ)) u_src (
    .irq_flag (irq_flag),
    .irq_en   (irq_en),
    .wdt_tmo  (wdt_tmo),
    .irq_hit  (irq_hit),
    .wake     (wake)
  );

  lpw_ost_timer #(.OST_CYC(OST_CYC)) u_ost (
    .clk       (clk),
    .rst       (rst),
    .kill      (ost_kill),
    .start     (ost_start),
    .pri_ready (pri_ready),
    .done      (pri_good)
  );

  lpw_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .load (settle_load),
    .zero (settle_zero)
  );

  assign xtal       = osc_is_xtal(osc_type);
  assign intosc     = osc_is_int(osc_type);
  assign fast       = two_speed_en | fail_safe_en;
  assign run_on_int = intosc | (xtal & ~pri_good);
  assign low_pwr    = state_q[ST_IPRI] | state_q[ST_IOTH] | state_q[ST_SLEEP];

  always_comb begin
    nxt         = state_q;
    ost_kill    = 1'b0;
    ost_start   = 1'b0;
    settle_load = 1'b0;
    wake_take   = 1'b0;
    unique case (1'b1)
      state_q[ST_RUN]: begin
        if (enter_sleep) begin
          nxt      = state_t'(1) << ST_SLEEP;
          ost_kill = 1'b1;
        end else if (enter_idle && idle_keep_pri) begin
          nxt      = state_t'(1) << ST_IPRI;
          ost_kill = ~pri_good;   // a clock still starting is shut down
        end else if (enter_idle) begin
          nxt      = state_t'(1) << ST_IOTH;
          ost_kill = 1'b1;
        end
      end
      low_pwr: begin
        if (wake) begin
          wake_take = 1'b1;
          ost_start = xtal & ~pri_good;
          if (xtal && !pri_good && !fast) begin
            nxt = state_t'(1) << ST_OSTW;
          end else begin
            nxt         = state_t'(1) << ST_SETL;
            settle_load = 1'b1;
          end
        end
      end
      state_q[ST_OSTW]: begin
        if (waking_q) begin
          if (pri_good) begin
            nxt         = state_t'(1) << ST_SETL;
            settle_load = 1'b1;
          end
        end else if (!xtal || fast || pri_good) begin
          nxt = state_t'(1) << ST_RUN;
        end
      end
      state_q[ST_SETL]: begin
        if (settle_zero)
          nxt = state_t'(1) << ST_RUN;
      end
      default: nxt = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= state_t'(1) << ST_OSTW;
      waking_q    <= 1'b0;
      vec_pend_q  <= 1'b0;
      cpu_run     <= 1'b0;
      vec_req     <= 1'b0;
      clk_int_sel <= 1'b0;
      stat_pri    <= 1'b0;
      stat_int    <= 1'b0;
    end else begin
      state_q <= nxt;
      if (wake_take) begin
        waking_q   <= 1'b1;
        vec_pend_q <= irq_hit & gie;
      end else if (nxt[ST_RUN]) begin
        waking_q   <= 1'b0;
        vec_pend_q <= 1'b0;
      end
      cpu_run     <= nxt[ST_RUN];
      vec_req     <= nxt[ST_RUN] & ~state_q[ST_RUN] & vec_pend_q;
      clk_int_sel <= run_on_int;
      stat_pri    <= ~nxt[ST_OSTW] & ~run_on_int;
      stat_int    <= ~nxt[ST_OSTW] & run_on_int;
    end
  end
endmodule

// File: rtl/lpw_checker.sv
module lpw_checker
  import lpw_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input state_t state_q,
  input logic   cpu_run,
  input logic   vec_req,
  input logic   stat_pri,
  input logic   stat_int,
  input logic   wdt_tmo,
  input logic   enter_sleep,
  input logic   enter_idle,
  input logic   settle_zero
);
  assert_onehot_state_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot(state_q));

  assert_vec_with_run_R3: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> cpu_run);

  assert_vec_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> !vec_req);

  assert_status_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(stat_pri && stat_int));

  assert_run_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_run) |-> ($past(state_q[ST_SETL]) || $past(state_q[ST_OSTW])));

  assert_settle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q[ST_SETL] && !settle_zero) |=> state_q[ST_SETL]);

  assert_wdt_run_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q[ST_RUN] && wdt_tmo && !enter_sleep && !enter_idle) |=> state_q[ST_RUN]);
endmodule

bind lp_wake_seq lpw_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .state_q     (state_q),
  .cpu_run     (cpu_run),
  .vec_req     (vec_req),
  .stat_pri    (stat_pri),
  .stat_int    (stat_int),
  .wdt_tmo     (wdt_tmo),
  .enter_sleep (enter_sleep),
  .enter_idle  (enter_idle),
  .settle_zero (settle_zero)
);

// File: tb/tb_lp_wake_seq.sv
module tb_lp_wake_seq;
  localparam int NI = 3;
  localparam int SC = 5;
  localparam int OC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0] irq_flag = '0, irq_en = '0;
  logic gie = 1'b0, wdt_tmo = 1'b0;
  logic enter_sleep = 1'b0, enter_idle = 1'b0, idle_keep_pri = 1'b0;
  logic [2:0] osc_type = 3'd4;
  logic pri_ready = 1'b1, two_speed_en = 1'b0, fail_safe_en = 1'b0;
  logic cpu_run, vec_req, clk_int_sel, stat_pri, stat_int;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lp_wake_seq #(.N_IRQ(NI), .SETTLE_CYC(SC), .OST_CYC(OC)) dut (
    .clk(clk), .rst(rst), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
    .wdt_tmo(wdt_tmo), .enter_sleep(enter_sleep), .enter_idle(enter_idle),
    .idle_keep_pri(idle_keep_pri), .osc_type(osc_type), .pri_ready(pri_ready),
    .two_speed_en(two_speed_en), .fail_safe_en(fail_safe_en),
    .cpu_run(cpu_run), .vec_req(vec_req), .clk_int_sel(clk_int_sel),
    .stat_pri(stat_pri), .stat_int(stat_int)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts edges, first counted edge is the one right after the caller's negedge
  task automatic run_wait(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      wdt_tmo = 1'b0;
    end while (!cpu_run && n < 400);
  endtask

  task automatic clk_wait(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (clk_int_sel && n < 400);
  endtask

  task automatic boot(input logic [2:0] t, input logic ts, input logic fs, output int n);
    @(negedge clk);
    rst = 1'b1; osc_type = t; two_speed_en = ts; fail_safe_en = fs; pri_ready = 1'b1;
    irq_flag = '0; irq_en = '0; enter_sleep = 1'b0; enter_idle = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({cpu_run, vec_req, stat_pri, stat_int, clk_int_sel} == 5'b0, "R12 reset outputs",
        int'({cpu_run, vec_req, stat_pri, stat_int, clk_int_sel}), 0);
    rst = 1'b0;
    run_wait(n);
  endtask

  task automatic go_low(input logic sl, input logic id, input logic kp);
    enter_sleep = sl; enter_idle = id; idle_keep_pri = kp;
    @(posedge clk);
    @(negedge clk);
    enter_sleep = 1'b0; enter_idle = 1'b0;
    chk(cpu_run == 1'b0, "R11 run drops on entry", int'(cpu_run), 0);
  endtask

  initial begin
    int n, m;
    // R7: non-crystal types
    boot(3'd5, 1'b0, 1'b0, n);
    chk(n == 1, "R7 external clock start edges", n, 1);
    chk(stat_pri && !stat_int && !clk_int_sel, "R7 external clock status", int'({stat_pri, stat_int}), 2);
    boot(3'd6, 1'b0, 1'b0, n);
    chk(n == 1, "R7 internal osc start edges", n, 1);
    chk(clk_int_sel && stat_int && !stat_pri, "R7 internal osc status", int'({stat_pri, stat_int}), 1);

    // R1 / R2 / R3 / R4 sweep over all flag/enable pairs in clock-stopping idle
    boot(3'd4, 1'b0, 1'b0, n);
    for (int f = 0; f < 8; f++) begin
      for (int e = 0; e < 8; e++) begin
        logic expw;
        logic g;
        go_low(1'b0, 1'b1, 1'b0);
        irq_flag = NI'(f); irq_en = NI'(e);
        g = f[0] ^ e[1];
        gie = g;
        expw = |(NI'(f) & NI'(e));
        if (expw) begin
          run_wait(n);
          chk(n == SC + 1, "R1 R4 irq wake edges", n, SC + 1);
          chk(vec_req == g, "R3 vector on irq wake", int'(vec_req), int'(g));
          @(negedge clk);
          chk(vec_req == 1'b0, "R3 vector single cycle", int'(vec_req), 0);
        end else begin
          repeat (SC + 4) @(negedge clk);
          chk(cpu_run == 1'b0, "R1 disabled flag keeps idle", int'(cpu_run), 0);
          irq_flag = '0;
          wdt_tmo = 1'b1;
          run_wait(n);
          chk(n == SC + 1, "R2 watchdog wake edges", n, SC + 1);
          chk(vec_req == 1'b0, "R2 no vector on watchdog", int'(vec_req), 0);
        end
        irq_flag = '0;
      end
    end

    // R6: crystal reset exit
    boot(3'd2, 1'b0, 1'b0, n);
    chk(n == OC + 1, "R6 crystal reset edges", n, OC + 1);
    chk(stat_pri && !stat_int && !clk_int_sel, "R6 crystal status", int'({stat_pri, stat_int, clk_int_sel}), 4);

    // R11: watchdog in run ignored
    wdt_tmo = 1'b1;
    @(negedge clk);
    wdt_tmo = 1'b0;
    repeat (3) @(negedge clk);
    chk(cpu_run == 1'b1, "R11 watchdog in run ignored", int'(cpu_run), 1);

    // R4: primary-keeping idle with clock up
    go_low(1'b0, 1'b1, 1'b1);
    irq_flag = 3'b010; irq_en = 3'b010; gie = 1'b0;
    run_wait(n);
    chk(n == SC + 1, "R4 primary idle wake edges", n, SC + 1);
    chk(vec_req == 1'b0, "R3 no vector when gie low", int'(vec_req), 0);
    irq_flag = '0;
    @(negedge clk);

    // R5: sleep with crystal
    go_low(1'b1, 1'b0, 1'b0);
    irq_flag = 3'b001; irq_en = 3'b001; gie = 1'b1;
    run_wait(n);
    chk(n == OC + SC + 2, "R5 crystal sleep wake edges", n, OC + SC + 2);
    chk(vec_req == 1'b1, "R3 vector after crystal wake", int'(vec_req), 1);
    irq_flag = '0;
    @(negedge clk);

    // R11: sleep wins over idle (crystal path length shows sleep was taken)
    go_low(1'b1, 1'b1, 1'b1);
    wdt_tmo = 1'b1;
    run_wait(n);
    chk(n == OC + SC + 2, "R11 sleep priority", n, OC + SC + 2);

    // R6: late pri_ready holds start
    @(negedge clk);
    rst = 1'b1; osc_type = 3'd1; pri_ready = 1'b0; two_speed_en = 1'b0; fail_safe_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (OC + 15) @(negedge clk);
    chk(cpu_run == 1'b0, "R6 held until ready", int'(cpu_run), 0);
    pri_ready = 1'b1;
    run_wait(n);
    chk(n == 1, "R6 start after ready edges", n, 1);

    // R8: two-speed start
    boot(3'd1, 1'b1, 1'b0, n);
    chk(n == 1, "R8 fast start edges", n, 1);
    chk(clk_int_sel && stat_int && !stat_pri, "R8 fast start on internal", int'({stat_pri, stat_int, clk_int_sel}), 3);
    clk_wait(m);
    chk(n + m == OC + 1, "R8 switch to primary edges", n + m, OC + 1);
    chk(stat_pri && !stat_int, "R8 status after switch", int'({stat_pri, stat_int}), 2);
    boot(3'd3, 1'b0, 1'b1, n);
    chk(n == 1 && clk_int_sel, "R8 fail-safe fast start", n, 1);

    // R10: sleep before primary ready
    boot(3'd0, 1'b1, 1'b0, n);
    go_low(1'b1, 1'b0, 1'b0);
    repeat (OC + 5) @(negedge clk);
    irq_flag = 3'b100; irq_en = 3'b100; gie = 1'b0;
    run_wait(n);
    chk(n == SC + 1, "R10 fast wake edges", n, SC + 1);
    chk(clk_int_sel == 1'b1, "R10 primary was shut down", int'(clk_int_sel), 1);
    irq_flag = '0;
    clk_wait(m);
    chk(n + m == OC + 2, "R10 primary restart edges", n + m, OC + 2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule